// File: doc/BRIEF.md
# UART Chip-Type Probe Engine

This block works out which generation of 8250-family serial controller sits at a given base address on a byte-wide register bus. After a `start` pulse it captures the base address and a primary-port flag. It then masters the bus through a fixed script of register writes and read-backs. Each read either ends the script with a verdict or lets it move on to the next test. The tests look at how the register file aliases and hides itself: whether the divisor-high latch really stores a value, whether the interrupt-enable register is just showing the divisor through, whether a scratch byte is present, whether scratch vanishes behind the enhanced-feature window, what the FIFO identification bits report, and whether a flow-control bit in modem control can be set.

The verdict is a 4-bit type code: 0 none, 1 8250, 2 16450, 3 16550, 4 16550A, 5 16550C, 6 16650, 7 16750, 8 16850. Code 8 is never produced, because the script cannot tell it apart from 16650. A `done` pulse lasting one cycle marks each new verdict. The code stays unchanged until the next verdict. A port flagged as primary is never reported absent.

The controller is a single enumerated state machine. `ST_IDLE` waits for `start`. Any `start` moves it to `ST_IER_CLR`, from every state. Each of the following states performs one bus access. When that access completes, the state either advances to the next one in script order or, on a decisive read, returns to `ST_IDLE`. The script order is: `ST_IER_CLR`, `ST_LCR_DIV`, `ST_DLM_PUT`, `ST_DLM_GET`, `ST_LCR_NORM`, `ST_IER_GET`, `ST_SCR_PUT`, `ST_SCR_GET`, `ST_LCR_FEAT`, `ST_SCR_REGET`, `ST_LCR_REDIV`, `ST_FCR_PUT`, `ST_IIR_GET`, `ST_MCR_PUT`, `ST_MCR_GET`. The last of these always returns to `ST_IDLE`.

Top module: `uart_type_probe`

## Requirements
- R1: After reset `done` is 0, `type_code` is 0 and neither `bus_wr` nor `bus_rd` is asserted until `start`.
- R2: Every access drives `bus_addr` = captured base OR register offset and asserts exactly one of `bus_wr`/`bus_rd`. It holds address, direction and write data until a cycle with `bus_ready` high completes it. Read data is taken in that cycle.
- R3: The script opens with these writes: offset 1 ← 0x00, offset 3 ← 0x80, offset 1 ← 0x5A. It then reads offset 1. Any value other than 0x5A ends with code 0.
- R4: Next it writes offset 3 ← 0x00 and reads offset 1. A value of 0x5A ends with code 0.
- R5: Next it writes offset 7 ← 0x5A and reads offset 7. Any value other than 0x5A ends with code 1.
- R6: Next it writes offset 3 ← 0xBF and reads offset 7. Any value other than 0x5A ends with code 6.
- R7: Next it writes offset 3 ← 0x80 and offset 2 ← 0xE7, then reads offset 2. If bit 6 is clear the code is 2. Otherwise, if bit 7 is clear the code is 3. Otherwise, if bit 5 is set the code is 7.
- R8: Otherwise it writes offset 4 ← 0x20 and reads offset 4. If bit 5 is set the code is 5, otherwise 4. `type_code` never exceeds 8.
- R9: When `primary` was high at `start`, every outcome that would give code 0 gives code 1 instead.
- R10: `done` is high for exactly one cycle, the cycle after the deciding read completes. `type_code` changes only in a cycle where `done` is high, and then holds.
- R11: A `start` in any state abandons the current script and begins again at the first write. `base_addr` and `primary` are sampled only at `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) a probe |
| base_addr | input | ADDR_W | Base address of the device under probe |
| primary | input | 1 | Port is the primary one; never report absent |
| bus_addr | output | ADDR_W | Register address, base OR offset |
| bus_wdata | output | 8 | Write data |
| bus_wr | output | 1 | Write strobe, held until ready |
| bus_rd | output | 1 | Read strobe, held until ready |
| bus_rdata | input | 8 | Read data, valid with ready during a read |
| bus_ready | input | 1 | Completes the pending access |
| type_code | output | 4 | Detected device type |
| done | output | 1 | One-cycle pulse with a new verdict |

## Verification
The assertions assume that the bus only reports `bus_ready` in a way the strobe-hold rule can tolerate, and that `start` is the only event allowed to break off an access while it waits. Under those assumptions, address, direction and data must stay still until completion. The stimulus never lets the device model grant an access that is not pending. It delays each grant for zero to two cycles using a shift-register pattern, and it freezes the bus model whenever it restarts a probe. Read data is changed only together with a grant, so the value the block samples is always the scripted reply for the read that is pending.

// File: rtl/uart_probe_pkg.sv
package uart_probe_pkg;

    localparam int OFS_W = 3;
    localparam int DAT_W = 8;

    localparam logic [OFS_W-1:0] OFS_IER = 3'd1;
    localparam logic [OFS_W-1:0] OFS_DLM = 3'd1;
    localparam logic [OFS_W-1:0] OFS_FIFO = 3'd2;
    localparam logic [OFS_W-1:0] OFS_LCR = 3'd3;
    localparam logic [OFS_W-1:0] OFS_MCR = 3'd4;
    localparam logic [OFS_W-1:0] OFS_SCR = 3'd7;

    localparam logic [DAT_W-1:0] PROBE_PAT = 8'h5A;
    localparam logic [DAT_W-1:0] LCR_DIVSEL = 8'h80;
    localparam logic [DAT_W-1:0] LCR_FEATWIN = 8'hBF;
    localparam logic [DAT_W-1:0] FIFO_TEST = 8'hE7;
    localparam logic [DAT_W-1:0] MCR_FLOWBIT = 8'h20;

    typedef enum logic [3:0] {
        TC_NONE   = 4'd0,
        TC_8250   = 4'd1,
        TC_16450  = 4'd2,
        TC_16550  = 4'd3,
        TC_16550A = 4'd4,
        TC_16550C = 4'd5,
        TC_16650  = 4'd6,
        TC_16750  = 4'd7,
        TC_16850  = 4'd8
    } type_code_e;

    typedef enum logic [4:0] {
        ST_IDLE, ST_IER_CLR, ST_LCR_DIV, ST_DLM_PUT, ST_DLM_GET,
        ST_LCR_NORM, ST_IER_GET, ST_SCR_PUT, ST_SCR_GET, ST_LCR_FEAT,
        ST_SCR_REGET, ST_LCR_REDIV, ST_FCR_PUT, ST_IIR_GET, ST_MCR_PUT,
        ST_MCR_GET
    } state_e;

    typedef struct packed {
        logic             wr;
        logic [OFS_W-1:0] ofs;
        logic [DAT_W-1:0] data;
    } bus_op_t;

    // Bus access performed in each script state.
    function automatic bus_op_t op_of(state_e s);
        bus_op_t o;
        o = '{wr: 1'b0, ofs: '0, data: '0};
        unique case (s)
            ST_IER_CLR:   o = '{wr: 1'b1, ofs: OFS_IER,  data: 8'h00};
            ST_LCR_DIV:   o = '{wr: 1'b1, ofs: OFS_LCR,  data: LCR_DIVSEL};
            ST_DLM_PUT:   o = '{wr: 1'b1, ofs: OFS_DLM,  data: PROBE_PAT};
            ST_DLM_GET:   o = '{wr: 1'b0, ofs: OFS_DLM,  data: 8'h00};
            ST_LCR_NORM:  o = '{wr: 1'b1, ofs: OFS_LCR,  data: 8'h00};
            ST_IER_GET:   o = '{wr: 1'b0, ofs: OFS_IER,  data: 8'h00};
            ST_SCR_PUT:   o = '{wr: 1'b1, ofs: OFS_SCR,  data: PROBE_PAT};
            ST_SCR_GET:   o = '{wr: 1'b0, ofs: OFS_SCR,  data: 8'h00};
            ST_LCR_FEAT:  o = '{wr: 1'b1, ofs: OFS_LCR,  data: LCR_FEATWIN};
            ST_SCR_REGET: o = '{wr: 1'b0, ofs: OFS_SCR,  data: 8'h00};
            ST_LCR_REDIV: o = '{wr: 1'b1, ofs: OFS_LCR,  data: LCR_DIVSEL};
            ST_FCR_PUT:   o = '{wr: 1'b1, ofs: OFS_FIFO, data: FIFO_TEST};
            ST_IIR_GET:   o = '{wr: 1'b0, ofs: OFS_FIFO, data: 8'h00};
            ST_MCR_PUT:   o = '{wr: 1'b1, ofs: OFS_MCR,  data: MCR_FLOWBIT};
            ST_MCR_GET:   o = '{wr: 1'b0, ofs: OFS_MCR,  data: 8'h00};
            default:      o = '{wr: 1'b0, ofs: '0, data: '0};
        endcase
        return o;
    endfunction

    // Script order when a step does not end the probe.
    function automatic state_e next_of(state_e s);
        state_e n;
        unique case (s)
            ST_IER_CLR:   n = ST_LCR_DIV;
            ST_LCR_DIV:   n = ST_DLM_PUT;
            ST_DLM_PUT:   n = ST_DLM_GET;
            ST_DLM_GET:   n = ST_LCR_NORM;
            ST_LCR_NORM:  n = ST_IER_GET;
            ST_IER_GET:   n = ST_SCR_PUT;
            ST_SCR_PUT:   n = ST_SCR_GET;
            ST_SCR_GET:   n = ST_LCR_FEAT;
            ST_LCR_FEAT:  n = ST_SCR_REGET;
            ST_SCR_REGET: n = ST_LCR_REDIV;
            ST_LCR_REDIV: n = ST_FCR_PUT;
            ST_FCR_PUT:   n = ST_IIR_GET;
            ST_IIR_GET:   n = ST_MCR_PUT;
            ST_MCR_PUT:   n = ST_MCR_GET;
            default:      n = ST_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/probe_bus_port.sv
module probe_bus_port
    import uart_probe_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  bus_op_t           op,
    input  logic [ADDR_W-1:0] base,
    input  logic              bus_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DAT_W-1:0]  bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic              ack
);
    localparam int PAD_W = ADDR_W - OFS_W;

    assign bus_addr  = base | {{PAD_W{1'b0}}, op.ofs};
    assign bus_wr    = active & op.wr;
    assign bus_rd    = active & ~op.wr;
    assign bus_wdata = op.wr ? op.data : '0;
    assign ack       = active & bus_ready;

    // R2: one direction per access
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

endmodule

// File: rtl/probe_verdict.sv
module probe_verdict
    import uart_probe_pkg::*;
(
    input  state_e           st,
    input  logic [DAT_W-1:0] rdata,
    input  logic             primary,
    output logic             finish,
    output type_code_e       code
);
    type_code_e absent;

    assign absent = primary ? TC_8250 : TC_NONE;

    always_comb begin
        finish = 1'b0;
        code   = TC_NONE;
        unique case (st)
            ST_DLM_GET: if (rdata != PROBE_PAT) begin
                finish = 1'b1; code = absent;
            end
            ST_IER_GET: if (rdata == PROBE_PAT) begin
                finish = 1'b1; code = absent;
            end
            ST_SCR_GET: if (rdata != PROBE_PAT) begin
                finish = 1'b1; code = TC_8250;
            end
            ST_SCR_REGET: if (rdata != PROBE_PAT) begin
                finish = 1'b1; code = TC_16650;
            end
            ST_IIR_GET: begin
                if (!rdata[6]) begin
                    finish = 1'b1; code = TC_16450;
                end else if (!rdata[7]) begin
                    finish = 1'b1; code = TC_16550;
                end else if (rdata[5]) begin
                    finish = 1'b1; code = TC_16750;
                end
            end
            ST_MCR_GET: begin
                finish = 1'b1;
                code   = rdata[5] ? TC_16550C : TC_16550A;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/probe_seq.sv
module probe_seq
    import uart_probe_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              primary_in,
    input  logic              ack,
    input  logic              finish,
    input  type_code_e        code_in,
    output state_e            st,
    output logic [ADDR_W-1:0] base_q,
    output logic              prim_q,
    output logic              done,
    output logic [3:0]        type_code
);
    state_e     st_nx;
    type_code_e code_q;
    logic       verdict;

    assign verdict = ack && finish && (st != ST_IDLE);

    always_comb begin
        st_nx = st;
        if (start)
            st_nx = ST_IER_CLR;
        else if (ack && st != ST_IDLE)
            st_nx = finish ? ST_IDLE : next_of(st);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            base_q <= '0;
            prim_q <= 1'b0;
        end else begin
            st <= st_nx;
            if (start) begin
                base_q <= base_in;
                prim_q <= primary_in;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            code_q <= TC_NONE;
        end else begin
            done <= verdict && !start;
            if (verdict && !start)
                code_q <= code_in;
        end
    end

    assign type_code = code_q;

    // R10: done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: code changes only with done
    a_r10_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(type_code));
    // R8: code stays within the defined set
    a_r8_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        type_code <= 4'd8);

endmodule

// File: rtl/uart_type_probe.sv
module uart_type_probe
    import uart_probe_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              primary,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ready,
    output logic [3:0]        type_code,
    output logic              done
);
    state_e            st;
    logic [ADDR_W-1:0] base_q;
    logic              prim_q;
    logic              ack;
    logic              finish;
    type_code_e        code;

    probe_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .base_in(base_addr),
        .primary_in(primary), .ack(ack), .finish(finish), .code_in(code),
        .st(st), .base_q(base_q), .prim_q(prim_q), .done(done),
        .type_code(type_code)
    );

    probe_bus_port #(.ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .active(st != ST_IDLE), .op(op_of(st)),
        .base(base_q), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .ack(ack)
    );

    probe_verdict u_verdict (
        .st(st), .rdata(bus_rdata), .primary(prim_q),
        .finish(finish), .code(code)
    );

    // R2: a pending access holds until ready
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && !bus_ready && !start) |=>
            (bus_wr == $past(bus_wr)) && (bus_rd == $past(bus_rd)) &&
            $stable(bus_addr) && $stable(bus_wdata));
    // R10: a verdict follows a completed read
    a_r10_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_rd && bus_ready));

endmodule

// File: tb/tb_uart_type_probe.sv
module tb_uart_type_probe;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       primary = 1'b0;
    logic [7:0] base_addr = 8'h00;
    logic [7:0] bus_rdata = 8'h00;
    logic       bus_ready = 1'b0;
    logic [7:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_wr;
    logic       bus_rd;
    logic [3:0] type_code;
    logic       done;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_type_probe dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .primary(primary), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .type_code(type_code), .done(done)
    );

    // kind: 0 write, 1 read, 2 verdict
    typedef struct {
        int         kind;
        logic [7:0] addr;
        logic [7:0] data;
        string      tag;
    } item_t;

    item_t      expq[$];
    int         checks = 0;
    int         fails = 0;
    bit         hold = 1'b0;
    bit         seen_done = 1'b0;
    logic [7:0] lfsr = 8'h5B;
    int         stall = 0;
    logic [7:0] cur_base = 8'h00;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // monitor and device model
    always @(negedge clk) begin
        item_t it;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (!rst_n || hold) begin
            bus_ready = 1'b0;
        end else begin
            if (done) begin
                if (expq.size() > 0 && expq[0].kind == 2) begin
                    it = expq.pop_front();
                    chk(type_code == it.data[3:0], it.tag, "type code", type_code, it.data);
                end else begin
                    chk(1'b0, "R10", "unexpected done", 1, 0);
                end
                seen_done = 1'b1;
            end
            if (bus_wr || bus_rd) begin
                if (lfsr[0] || stall >= 2) begin
                    stall = 0;
                    bus_ready = 1'b1;
                    if (expq.size() == 0 || expq[0].kind == 2) begin
                        chk(1'b0, "R2", "unexpected access", bus_addr, 0);
                    end else begin
                        it = expq.pop_front();
                        chk(bus_wr == (it.kind == 0) && bus_rd == (it.kind == 1),
                            it.tag, "direction wr", bus_wr, (it.kind == 0));
                        chk(bus_addr == it.addr, it.tag, "address", bus_addr, it.addr);
                        if (it.kind == 0)
                            chk(bus_wdata == it.data, it.tag, "write data", bus_wdata, it.data);
                        else
                            bus_rdata = it.data;
                    end
                end else begin
                    stall++;
                    bus_ready = 1'b0;
                end
            end else begin
                bus_ready = 1'b0;
            end
        end
    end

    task automatic pw(int ofs, int d, string tag);
        expq.push_back('{0, cur_base | 8'(ofs), 8'(d), tag});
    endtask

    task automatic pr(int ofs, int d, string tag);
        expq.push_back('{1, cur_base | 8'(ofs), 8'(d), tag});
    endtask

    // expected script from the requirements
    task automatic prepare(input logic [7:0] base, input bit prim,
                           input logic [7:0] dlm, input logic [7:0] ier,
                           input logic [7:0] scr, input logic [7:0] scr2,
                           input logic [7:0] iir, input logic [7:0] mcr);
        bit    fin;
        int    code;
        string tg;
        expq.delete();
        cur_base = base;
        fin = 1'b0;
        code = 0;
        tg = "R3";
        pw(1, 8'h00, "R3"); pw(3, 8'h80, "R3"); pw(1, 8'h5A, "R3"); pr(1, dlm, "R3");
        if (dlm != 8'h5A) begin
            fin = 1'b1; code = prim ? 1 : 0; tg = prim ? "R9" : "R3";
        end
        if (!fin) begin
            pw(3, 8'h00, "R4"); pr(1, ier, "R4");
            if (ier == 8'h5A) begin
                fin = 1'b1; code = prim ? 1 : 0; tg = prim ? "R9" : "R4";
            end
        end
        if (!fin) begin
            pw(7, 8'h5A, "R5"); pr(7, scr, "R5");
            if (scr != 8'h5A) begin fin = 1'b1; code = 1; tg = "R5"; end
        end
        if (!fin) begin
            pw(3, 8'hBF, "R6"); pr(7, scr2, "R6");
            if (scr2 != 8'h5A) begin fin = 1'b1; code = 6; tg = "R6"; end
        end
        if (!fin) begin
            pw(3, 8'h80, "R7"); pw(2, 8'hE7, "R7"); pr(2, iir, "R7");
            tg = "R7";
            if (!iir[6]) begin fin = 1'b1; code = 2; end
            else if (!iir[7]) begin fin = 1'b1; code = 3; end
            else if (iir[5]) begin fin = 1'b1; code = 7; end
        end
        if (!fin) begin
            pw(4, 8'h20, "R8"); pr(4, mcr, "R8");
            code = mcr[5] ? 5 : 4; tg = "R8";
        end
        expq.push_back('{2, 8'h00, 8'(code), tg});
    endtask

    task automatic launch(input logic [7:0] base, input bit prim);
        @(posedge clk); #1;
        base_addr = base; primary = prim; start = 1'b1; seen_done = 1'b0;
        @(posedge clk); #1;
        start = 1'b0;
        // R11: inputs after start must not matter
        base_addr = ~base; primary = ~prim;
        hold = 1'b0;
    endtask

    task automatic finish_case();
        int   n;
        logic [3:0] got;
        n = 0;
        while (!seen_done && n < 400) begin
            @(negedge clk); n++;
        end
        chk(seen_done, "R10", "done seen", seen_done, 1);
        chk(expq.size() == 0, "R2", "script fully consumed", expq.size(), 0);
        got = type_code;
        repeat (3) @(negedge clk);
        chk(!done && type_code == got, "R10", "code held, done low", type_code, got);
    endtask

    task automatic run_case(input logic [7:0] base, input bit prim,
                            input logic [7:0] dlm, input logic [7:0] ier,
                            input logic [7:0] scr, input logic [7:0] scr2,
                            input logic [7:0] iir, input logic [7:0] mcr);
        prepare(base, prim, dlm, ier, scr, scr2, iir, mcr);
        launch(base, prim);
        finish_case();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(type_code == 4'd0 && !done && !bus_wr && !bus_rd, "R1",
            "reset state", {done, bus_wr, bus_rd, type_code}, 0);
        repeat (2) @(negedge clk);
        chk(!bus_wr && !bus_rd, "R1", "quiet before start", {bus_wr, bus_rd}, 0);

        run_case(8'hC0, 1'b0, 8'hFF, 8'h00, 8'h5A, 8'h5A, 8'hC1, 8'h00); // R3 absent
        run_case(8'h68, 1'b1, 8'h00, 8'h00, 8'h5A, 8'h5A, 8'hC1, 8'h00); // R9
        run_case(8'hA8, 1'b0, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'hC1, 8'h00); // R4
        run_case(8'hA8, 1'b1, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'hC1, 8'h00); // R9
        run_case(8'h48, 1'b0, 8'h5A, 8'h00, 8'hFF, 8'h5A, 8'hC1, 8'h00); // R5
        run_case(8'h80, 1'b0, 8'h5A, 8'h00, 8'h5A, 8'h00, 8'hC1, 8'h00); // R6
        run_case(8'hD0, 1'b0, 8'h5A, 8'h00, 8'h5A, 8'h5A, 8'h81, 8'h00); // R7 16450
        run_case(8'hD8, 1'b0, 8'h5A, 8'h00, 8'h5A, 8'h5A, 8'h41, 8'h00); // R7 16550
        run_case(8'hC8, 1'b0, 8'h5A, 8'h00, 8'h5A, 8'h5A, 8'hE1, 8'h00); // R7 16750
        run_case(8'hC0, 1'b0, 8'h5A, 8'h00, 8'h5A, 8'h5A, 8'hC1, 8'h20); // R8 16550C
        run_case(8'hC0, 1'b1, 8'h5A, 8'h00, 8'h5A, 8'h5A, 8'hC1, 8'h00); // R8 16550A

        // R11: restart mid-script
        prepare(8'hA0, 1'b0, 8'h5A, 8'h00, 8'h5A, 8'h5A, 8'hC1, 8'h00);
        launch(8'hA0, 1'b0);
        begin
            int n;
            n = 0;
            while (expq.size() > 10 && n < 200) begin
                @(negedge clk); n++;
            end
        end
        @(posedge clk); #1;
        hold = 1'b1;
        prepare(8'hB8, 1'b0, 8'h5A, 8'h00, 8'h5A, 8'h00, 8'hC1, 8'h00);
        chk(!done, "R11", "no verdict before restart", done, 0);
        launch(8'hB8, 1'b0);
        finish_case();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule